// File: doc/BRIEF.md
# Eight-Bit Bit-Sliced Arithmetic-Logic Unit

This block is a purely combinational arithmetic-logic unit. It is assembled from a row of identical one-bit slices, and each slice holds a full adder. The carry ripples from the lowest slice to the highest. Before any function is chosen, the two operands pass through gating. Operand A can be forced to zero and then inverted, operand B can be forced to zero, and a separate carry-in line feeds the lowest slice. A single adder therefore produces A+B, A+1, B-A, -A, the constants 0, 1 and -1, and the plain logic functions.

Two select lines pick one of four functions: bitwise AND, bitwise OR, complement of the gated B operand, or the sum. Three flags come with the result. The sign flag copies the top result bit. The zero flag marks an all-zero result. The overflow flag reports signed overflow of the sum. A signed "A less than B" test can be built from these outputs: subtract, then take the sign corrected by overflow.

The block holds no state. Every output follows from the current inputs alone. It has no state machine, so no states or transitions exist to list.

Top module: `bsalu_core`

## Requirements
- R1: The gated operands are `ea = (a_in AND en_a) XOR inv_a` and `eb = b_in AND en_b`, with each control applied to every bit. Every function acts on `ea` and `eb`, never on the raw operands.
- R2: The select value `{fsel0,fsel1}` picks the function. 2'b00 gives `ea AND eb`, 2'b01 gives `ea OR eb`, 2'b10 gives `NOT eb`, and 2'b11 gives the sum.
- R3: With select 2'b11, `result` equals `(ea + eb + carry_in) mod 256`.
- R4: With select values 2'b00, 2'b01 or 2'b10, `carry_in` has no effect on `result`, `neg`, `zero` or `ovf`.
- R5: `neg` equals bit 7 of `result` for every function.
- R6: `zero` is 1 exactly when all eight `result` bits are 0, for every function.
- R7: `ovf` is 1 exactly when the select is 2'b11 and the sum overflows as a signed two's-complement value. That happens when `ea` and `eb` have the same sign bit and `result` has the other sign. `ovf` is 0 for every other select value.
- R8: Set select 2'b11, `en_a=1`, `en_b=1`, `inv_a=1` and `carry_in=1`, and drive x on `a_in` and y on `b_in`. Then `neg XOR ovf` is 1 exactly when y < x as signed 8-bit values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_in | input | 8 | Operand A |
| b_in | input | 8 | Operand B |
| fsel0 | input | 1 | Function select, upper bit of the select value |
| fsel1 | input | 1 | Function select, lower bit of the select value |
| en_a | input | 1 | Passes operand A when 1, forces it to zero when 0 |
| en_b | input | 1 | Passes operand B when 1, forces it to zero when 0 |
| inv_a | input | 1 | Inverts the gated A operand |
| carry_in | input | 1 | Carry into the lowest slice |
| result | output | 8 | Function result |
| neg | output | 1 | Sign of the result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow of the sum |

## Verification
The bench builds the block with its default width of eight. At that width every one of the 64 control combinations can be paired with many operand patterns in a short run. The patterns include the sign-boundary values 0x7F, 0x80 and 0xFF, where overflow and wrap to zero occur. A full 16-by-16 grid of signed operand pairs covers the less-than derivation on both sides of the sign boundary.

// File: rtl/bsalu_pkg.sv
package bsalu_pkg;

    typedef enum logic [1:0] {
        FN_AND  = 2'b00,
        FN_OR   = 2'b01,
        FN_NOTB = 2'b10,
        FN_SUM  = 2'b11
    } alu_fn_e;

    typedef struct packed {
        logic en_a;
        logic en_b;
        logic inv_a;
    } opnd_ctl_t;

endpackage

// File: rtl/bsalu_full_adder.sv
module bsalu_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic hs;

    always_comb begin
        hs = x ^ y;
        s  = hs ^ ci;
        co = (x & y) | (hs & ci);
    end
endmodule

// File: rtl/bsalu_slice.sv
module bsalu_slice
    import bsalu_pkg::*;
(
    input  logic      a_bit,
    input  logic      b_bit,
    input  opnd_ctl_t ctl,
    input  alu_fn_e   fn,
    input  logic      cin,
    output logic      res,
    output logic      cout
);
    logic ea;
    logic eb;
    logic fa_s;
    logic fa_c;

    always_comb begin
        ea = (a_bit & ctl.en_a) ^ ctl.inv_a;
        eb = b_bit & ctl.en_b;
    end

    bsalu_full_adder u_fa (
        .x  (ea),
        .y  (eb),
        .ci (cin),
        .s  (fa_s),
        .co (fa_c)
    );

    always_comb begin
        unique case (fn)
            FN_AND:  res = ea & eb;
            FN_OR:   res = ea | eb;
            FN_NOTB: res = ~eb;
            FN_SUM:  res = fa_s;
            default: res = 1'b0;
        endcase
        cout = (fn == FN_SUM) ? fa_c : 1'b0;
    end

    always_comb begin
        if (fn == FN_SUM) begin
            AST_SLICE_ADD: assert ({cout, res} == 2'({1'b0, ea} + {1'b0, eb} + {1'b0, cin}))
                else $error("slice sum mismatch"); // R3
        end else begin
            AST_CARRY_QUIET: assert (cout == 1'b0)
                else $error("carry leaked outside sum"); // R4
        end
    end
endmodule

// File: rtl/bsalu_flags.sv
module bsalu_flags #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] res,
    input  logic             c_into_msb,
    input  logic             c_out_msb,
    input  logic             is_sum,
    output logic             neg,
    output logic             zero,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        neg  = res[MSB];
        zero = ~|res;
        ovf  = is_sum & (c_into_msb ^ c_out_msb);
    end
endmodule

// File: rtl/bsalu_core.sv
module bsalu_core
    import bsalu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             fsel0,
    input  logic             fsel1,
    input  logic             en_a,
    input  logic             en_b,
    input  logic             inv_a,
    input  logic             carry_in,
    output logic [WIDTH-1:0] result,
    output logic             neg,
    output logic             zero,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    alu_fn_e          fn;
    opnd_ctl_t        ctl;
    logic [WIDTH:0]   carry;

    always_comb begin
        fn        = alu_fn_e'({fsel0, fsel1});
        ctl.en_a  = en_a;
        ctl.en_b  = en_b;
        ctl.inv_a = inv_a;
    end

    assign carry[0] = carry_in;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        bsalu_slice u_slice (
            .a_bit (a_in[i]),
            .b_bit (b_in[i]),
            .ctl   (ctl),
            .fn    (fn),
            .cin   (carry[i]),
            .res   (result[i]),
            .cout  (carry[i+1])
        );
    end

    bsalu_flags #(.WIDTH(WIDTH)) u_flags (
        .res        (result),
        .c_into_msb (carry[MSB]),
        .c_out_msb  (carry[WIDTH]),
        .is_sum     (fn == FN_SUM),
        .neg        (neg),
        .zero       (zero),
        .ovf        (ovf)
    );

    logic [WIDTH-1:0] ref_ea;
    logic [WIDTH-1:0] ref_eb;
    logic [WIDTH-1:0] ref_sum;

    always_comb begin
        ref_ea  = (a_in & {WIDTH{en_a}}) ^ {WIDTH{inv_a}};
        ref_eb  = b_in & {WIDTH{en_b}};
        ref_sum = ref_ea + ref_eb + WIDTH'(carry_in);
        if (fn == FN_SUM) begin
            AST_SUM_RESULT: assert (result == ref_sum)
                else $error("ripple sum mismatch"); // R3
            AST_OVF_SIGN: assert (ovf == ((ref_ea[MSB] == ref_eb[MSB]) && (result[MSB] != ref_ea[MSB])))
                else $error("overflow flag mismatch"); // R7
        end else begin
            AST_OVF_QUIET: assert (!ovf)
                else $error("overflow outside sum"); // R7
        end
        if (fn == FN_NOTB) begin
            AST_NOTB_RESULT: assert (result == ~ref_eb)
                else $error("complement mismatch"); // R2
        end
        AST_ZERO_FLAG: assert (zero == (result == '0))
            else $error("zero flag mismatch"); // R6
        AST_NEG_FLAG: assert (neg == result[MSB])
            else $error("sign flag mismatch"); // R5
    end
endmodule

// File: tb/bsalu_core_tb_top.sv
module bsalu_core_tb_top;

    typedef struct {
        logic [7:0] a;
        logic [7:0] b;
        logic [5:0] ctl;
        logic [7:0] e_o;
        logic       e_n;
        logic       e_z;
        logic       e_v;
        logic       lt_chk;
        logic       e_lt;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] a_in = '0;
    logic [7:0] b_in = '0;
    logic       fsel0 = 1'b0, fsel1 = 1'b0, en_a = 1'b0, en_b = 1'b0;
    logic       inv_a = 1'b0, carry_in = 1'b0;
    logic [7:0] result;
    logic       neg, zero, ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;
    item_t q[$];

    always #2 clk = ~clk;

    bsalu_core dut_i (
        .a_in(a_in), .b_in(b_in), .fsel0(fsel0), .fsel1(fsel1),
        .en_a(en_a), .en_b(en_b), .inv_a(inv_a), .carry_in(carry_in),
        .result(result), .neg(neg), .zero(zero), .ovf(ovf)
    );

    // ctl = {fsel0, fsel1, en_a, en_b, inv_a, carry_in}
    function automatic item_t model(input logic [7:0] a, input logic [7:0] b, input logic [5:0] c);
        item_t it;
        logic [7:0] ea, eb, s;
        ea = (a & {8{c[3]}}) ^ {8{c[1]}};
        eb = b & {8{c[2]}};
        s  = ea + eb + {7'd0, c[0]};
        it.a = a; it.b = b; it.ctl = c;
        it.e_v = 1'b0;
        case (c[5:4])
            2'b00: it.e_o = ea & eb;
            2'b01: it.e_o = ea | eb;
            2'b10: it.e_o = ~eb;
            default: begin
                it.e_o = s;
                it.e_v = (ea[7] == eb[7]) && (s[7] != ea[7]);
            end
        endcase
        it.e_n = it.e_o[7];
        it.e_z = (it.e_o == 8'd0);
        it.lt_chk = 1'b0;
        it.e_lt = 1'b0;
        return it;
    endfunction

    task automatic drive(input logic [7:0] a, input logic [7:0] b, input logic [5:0] c, input bit lt);
        item_t it;
        @(posedge clk);
        it = model(a, b, c);
        it.lt_chk = lt;
        it.e_lt = ($signed(b) < $signed(a));
        a_in = a; b_in = b;
        {fsel0, fsel1, en_a, en_b, inv_a, carry_in} = c;
        q.push_back(it);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            if (it.ctl[5:4] == 2'b11)
                check(result == it.e_o, "R1/R3 sum result", result, it.e_o);
            else if (it.ctl[0])
                check(result == it.e_o, "R2/R4 logic result with carry_in set", result, it.e_o);
            else
                check(result == it.e_o, "R1/R2 logic result", result, it.e_o);
            check(neg == it.e_n, "R5 sign flag", neg, it.e_n);
            check(zero == it.e_z, "R6 zero flag", zero, it.e_z);
            if (it.ctl[5:4] != 2'b11)
                check(ovf == 1'b0, "R4/R7 overflow outside sum", ovf, 0);
            else
                check(ovf == it.e_v, "R7 overflow flag", ovf, it.e_v);
            if (it.lt_chk)
                check((neg ^ ovf) == it.e_lt, "R8 less-than", neg ^ ovf, it.e_lt);
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(result == 8'h00, "R2 reset-state result", result, 0);
        check(zero == 1'b1, "R6 reset-state zero", zero, 1);
        check(ovf == 1'b0 && neg == 1'b0, "R5/R7 reset-state flags", {neg, ovf}, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 64; c++) begin
            for (int k = 0; k < 48; k++) begin
                drive(8'(k * 53 + c), 8'((k * 29) ^ 8'hA5), 6'(c), 1'b0);
            end
            drive(8'h7F, 8'h01, 6'(c), 1'b0);
            drive(8'h80, 8'h80, 6'(c), 1'b0);
            drive(8'hFF, 8'h01, 6'(c), 1'b0);
            drive(8'h00, 8'hFF, 6'(c), 1'b0);
        end
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                drive(8'(i * 17 + 8), 8'(j * 17 + 3), 6'b111111, 1'b1);
            end
        end
        drive(8'h80, 8'h7F, 6'b111111, 1'b1);
        drive(8'h7F, 8'h80, 6'b111111, 1'b1);
        drive(8'h42, 8'h42, 6'b111111, 1'b1);
        repeat (3) @(posedge clk);
        done = 1'b1;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
        end
    end

    initial begin
        wait (done || $time > 400000);
        #1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule